// File: doc/BRIEF.md
# Interrupt Status Mask Controller

The block gathers sixteen event inputs, split into two banks of eight, into one interrupt line. Each input owns a sticky status bit and an enable (mask) bit. Every input of the first bank also has a programmable trigger: rising edge, falling edge, or level. The second bank always triggers on a rising edge. Software reads a status register to learn which events have happened. That read also clears the register, but any level-triggered input that is still present stays set.

A simple synchronous register bus gives access to the masks, the trigger codes, the status registers and a small pin-control field. The pin-control field sets how the interrupt line is driven: active high, active low, or a pulled-down open-drain style. For open-drain, the block provides an output-enable and holds the data low. Event inputs are taken to be synchronous to `clk` already.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register (statuses, masks, trigger codes, pin control) reads 0x00, `irq_pin` is 0 and `irq_oe` is 1.
- R2: A first-bank input with trigger code 00 sets its status bit on a 0-to-1 change, compared against its value at the previous clock. The bit stays 1 after the input falls, until its status register is read.
- R3: Trigger code 01 sets the status bit on a 1-to-0 change of the input. A 0-to-1 change has no effect.
- R4: Trigger code 10 sets the status bit on every clock while the input is 1. A status read leaves such a bit at 1 while the input is still 1, and clears it once the input has gone to 0.
- R5: Trigger code 11 (reserved) never sets a status bit.
- R6: A mask bit of 0 stops its input from setting status. It also makes that status bit read as 0 and stops it from driving the interrupt line. A mask bit of 1 enables the input.
- R7: A read strobe at address A loads `bus_rdata` at that clock edge; the value is visible in the next cycle. When no read is strobed, `bus_rdata` is 0x00. A read of address 0 or 1 returns the masked status and then clears it.
- R8: If an event arrives in the same cycle as a read of its status register, the read returns the old value and the event stays latched.
- R9: Second-bank inputs behave as rising-edge triggered. A second-bank input held high sets its status once only.
- R10: The interrupt is active while any unmasked status bit in either bank is 1. This follows in the cycle after the status bit is set.
- R11: The pin-control code sets the output:
  - 00 and 11: `irq_pin` equals active, `irq_oe` is 1.
  - 01: `irq_pin` equals NOT active, `irq_oe` is 1.
  - 10: `irq_pin` is 0 and `irq_oe` equals active.
- R12: The register map is as follows. Addresses 7 to 15 read 0x00.
  - 0: first-bank status.
  - 1: second-bank status.
  - 2: first-bank mask.
  - 3: trigger-code high bits.
  - 4: trigger-code low bits.
  - 5: second-bank mask.
  - 6: pin control, bits 1:0.

  Input i takes its trigger code from bit i of address 3 (high bit) and bit i of address 4 (low bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| src_a | input | 8 | First-bank event inputs |
| src_b | input | 8 | Second-bank event inputs |
| irq_pin | output | 1 | Interrupt line data |
| irq_oe | output | 1 | Interrupt line output-enable |

## Verification
Each internal state shows up at the ports within a cycle or two:
- A stale previous-input register shows up as a status bit set one cycle early or late. It also shows up as a bit set on the wrong edge, seen at the next status read.
- A status bit that misses clearing or latching changes `irq_pin` in the very next cycle.
- A wrong mask or trigger register shows up on its own readback one cycle after the strobe.

The bench compares `bus_rdata`, `irq_pin` and `irq_oe` against a behavioural model on every cycle. Any divergence is therefore caught in the cycle where it first appears.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int BANK_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_RSVD  = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        PIN_HIGH = 2'b00,
        PIN_LOW  = 2'b01,
        PIN_OPEN = 2'b10,
        PIN_RSVD = 2'b11
    } pin_mode_e;

    localparam logic [ADDR_W-1:0] A_STAT_A  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT_B  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK_A  = 4'd2;
    localparam logic [ADDR_W-1:0] A_MODE_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_MODE_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_MASK_B  = 4'd5;
    localparam logic [ADDR_W-1:0] A_PIN_CTL = 4'd6;

    typedef struct packed {
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] mode_hi;
        logic [BANK_W-1:0] mode_lo;
    } bank_cfg_t;

    function automatic logic trig_hit(trig_mode_e m, logic now, logic was);
        logic r;
        case (m)
            TRIG_RISE:  r = now & ~was;
            TRIG_FALL:  r = ~now & was;
            TRIG_LEVEL: r = now;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_trigger.sv
module irq_trigger
    import irq_agg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic [W-1:0] mode_hi,
    input  logic [W-1:0] mode_lo,
    output logic [W-1:0] hit
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= src;
    end

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign hit[gi] = trig_hit(trig_mode_e'({mode_hi[gi], mode_lo[gi]}),
                                  src[gi], prev_q[gi]);
    end

endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] mask,
    input  logic         clr,
    output logic [W-1:0] status
);

    logic [W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= ((clr ? '0 : status_q) | hit) & mask;
    end

    assign status = status_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && $stable(mask)) |=> ((($past(status_q) & $past(mask)) & ~status_q) == '0)); // R2

    AST_READ_RACE_KEEP: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((($past(hit) & $past(mask)) & ~status_q) == '0)); // R8

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
    import irq_agg_pkg::*;
(
    input  pin_mode_e ctl,
    input  logic      active,
    output logic      pin,
    output logic      oe
);

    always_comb begin
        case (ctl)
            PIN_LOW: begin
                pin = ~active;
                oe  = 1'b1;
            end
            PIN_OPEN: begin
                pin = 1'b0;
                oe  = active;
            end
            default: begin
                pin = active;
                oe  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [BANK_W-1:0] src_a,
    input  logic [BANK_W-1:0] src_b,
    output logic              irq_pin,
    output logic              irq_oe
);

    localparam logic [BANK_W-1:0] RISE_ONLY = '0;

    bank_cfg_t         cfg_a;
    logic [BANK_W-1:0] mask_b;
    pin_mode_e         pin_ctl;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic [BANK_W-1:0] hit_a, hit_b, stat_a, stat_b;
    logic              rd_stat_a, rd_stat_b, irq_any;

    assign rd_stat_a = bus_rd && (bus_addr == A_STAT_A);
    assign rd_stat_b = bus_rd && (bus_addr == A_STAT_B);

    irq_trigger #(.W(BANK_W)) u_trig_a (
        .clk(clk), .rst(rst), .src(src_a),
        .mode_hi(cfg_a.mode_hi), .mode_lo(cfg_a.mode_lo), .hit(hit_a)
    );

    irq_trigger #(.W(BANK_W)) u_trig_b (
        .clk(clk), .rst(rst), .src(src_b),
        .mode_hi(RISE_ONLY), .mode_lo(RISE_ONLY), .hit(hit_b)
    );

    irq_sticky #(.W(BANK_W)) u_stat_a (
        .clk(clk), .rst(rst), .hit(hit_a), .mask(cfg_a.mask),
        .clr(rd_stat_a), .status(stat_a)
    );

    irq_sticky #(.W(BANK_W)) u_stat_b (
        .clk(clk), .rst(rst), .hit(hit_b), .mask(mask_b),
        .clr(rd_stat_b), .status(stat_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a   <= '0;
            mask_b  <= '0;
            pin_ctl <= PIN_HIGH;
        end else if (bus_wr) begin
            case (bus_addr)
                A_MASK_A:  cfg_a.mask    <= bus_wdata;
                A_MODE_HI: cfg_a.mode_hi <= bus_wdata;
                A_MODE_LO: cfg_a.mode_lo <= bus_wdata;
                A_MASK_B:  mask_b        <= bus_wdata;
                A_PIN_CTL: pin_ctl       <= pin_mode_e'(bus_wdata[1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            A_STAT_A:  rd_mux = stat_a & cfg_a.mask;
            A_STAT_B:  rd_mux = stat_b & mask_b;
            A_MASK_A:  rd_mux = cfg_a.mask;
            A_MODE_HI: rd_mux = cfg_a.mode_hi;
            A_MODE_LO: rd_mux = cfg_a.mode_lo;
            A_MASK_B:  rd_mux = mask_b;
            A_PIN_CTL: rd_mux = {{(DATA_W-2){1'b0}}, pin_ctl};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign irq_any   = (|(stat_a & cfg_a.mask)) | (|(stat_b & mask_b));

    irq_pin_drive u_pin (
        .ctl(pin_ctl), .active(irq_any), .pin(irq_pin), .oe(irq_oe)
    );

    AST_RD_MASKED_A: assert property (@(posedge clk) disable iff (rst)
        rd_stat_a |=> ((bus_rdata & ~$past(cfg_a.mask)) == '0)); // R6

    AST_RD_MASKED_B: assert property (@(posedge clk) disable iff (rst)
        rd_stat_b |=> ((bus_rdata & ~$past(mask_b)) == '0)); // R6

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
        !rd_stat_a |=> ((stat_a & ~$past(stat_a) & $past(cfg_a.mode_hi & cfg_a.mode_lo)) == '0)); // R5

    AST_B_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !rd_stat_b |=> ((stat_b & ~$past(stat_b) & ~$past(src_b)) == '0)); // R9

    AST_HIGH_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (pin_ctl == PIN_HIGH && irq_any) |-> irq_pin); // R10

    AST_OPEN_LOW: assert property (@(posedge clk) disable iff (rst)
        (pin_ctl == PIN_OPEN) |-> !irq_pin); // R11

    AST_OE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (pin_ctl != PIN_OPEN) |-> irq_oe); // R11

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0)); // R7

endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] src_a = '0, src_b = '0;
    logic       irq_pin, irq_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_a(src_a), .src_b(src_b), .irq_pin(irq_pin), .irq_oe(irq_oe)
    );

    // behavioural reference model
    logic [7:0] m_sa, m_sb, m_ma, m_mb, m_mh, m_ml, m_pa, m_pb, m_rd;
    logic [1:0] m_ctl;

    always @(posedge clk) begin : model
        logic [7:0] ha, rv;
        int code;
        if (rst) begin
            m_sa = 0; m_sb = 0; m_ma = 0; m_mb = 0; m_mh = 0; m_ml = 0;
            m_pa = 0; m_pb = 0; m_rd = 0; m_ctl = 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                code = m_mh[i] * 2 + m_ml[i];
                if (code == 0)      ha[i] = src_a[i] && !m_pa[i];
                else if (code == 1) ha[i] = !src_a[i] && m_pa[i];
                else if (code == 2) ha[i] = src_a[i];
                else                ha[i] = 1'b0;
            end
            rv = 0;
            if (bus_rd) begin
                if (bus_addr == 0)      rv = m_sa & m_ma;
                else if (bus_addr == 1) rv = m_sb & m_mb;
                else if (bus_addr == 2) rv = m_ma;
                else if (bus_addr == 3) rv = m_mh;
                else if (bus_addr == 4) rv = m_ml;
                else if (bus_addr == 5) rv = m_mb;
                else if (bus_addr == 6) rv = {6'd0, m_ctl};
            end
            m_rd = rv;
            m_sa = (((bus_rd && bus_addr == 0) ? 8'h00 : m_sa) | ha) & m_ma;
            m_sb = (((bus_rd && bus_addr == 1) ? 8'h00 : m_sb) | (src_b & ~m_pb)) & m_mb;
            if (bus_wr) begin
                if (bus_addr == 2)      m_ma = bus_wdata;
                else if (bus_addr == 3) m_mh = bus_wdata;
                else if (bus_addr == 4) m_ml = bus_wdata;
                else if (bus_addr == 5) m_mb = bus_wdata;
                else if (bus_addr == 6) m_ctl = bus_wdata[1:0];
            end
            m_pa = src_a;
            m_pb = src_b;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin : compare
        logic act, ep, eo;
        if (!rst && !done) begin
            act = (|(m_sa & m_ma)) | (|(m_sb & m_mb));
            if (m_ctl == 1)      begin ep = !act; eo = 1'b1; end
            else if (m_ctl == 2) begin ep = 1'b0; eo = act;  end
            else                 begin ep = act;  eo = 1'b1; end
            chk("R7 model rdata", bus_rdata, m_rd);
            chk("R10 model irq_pin", irq_pin, ep);
            chk("R11 model irq_oe", irq_oe, eo);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk("R1 irq_pin", irq_pin, 1'b0);
        chk("R1 irq_oe", irq_oe, 1'b1);
        for (int a = 0; a < 8; a++) rd(a[3:0], 8'h00, "R1 reset readback");
        // R12 map and trigger bit placement
        wr(4'd2, 8'hFF);
        wr(4'd5, 8'hFF);
        wr(4'd3, 8'h0C);
        wr(4'd4, 8'h0A);
        rd(4'd3, 8'h0C, "R12 mode high");
        rd(4'd4, 8'h0A, "R12 mode low");
        rd(4'd9, 8'h00, "R12 unmapped");
        // R2 rising
        src_a[0] = 1'b1; idle(1); src_a[0] = 1'b0; idle(2);
        chk("R10 irq after event", irq_pin, 1'b1);
        rd(4'd0, 8'h01, "R2 rising sticky");
        rd(4'd0, 8'h00, "R7 read cleared");
        chk("R10 irq idle", irq_pin, 1'b0);
        // R3 falling
        src_a[1] = 1'b1; idle(2);
        rd(4'd0, 8'h00, "R3 rise ignored");
        src_a[1] = 1'b0; idle(2);
        rd(4'd0, 8'h02, "R3 falling");
        // R4 level
        src_a[2] = 1'b1; idle(2);
        rd(4'd0, 8'h04, "R4 level set");
        rd(4'd0, 8'h04, "R4 level kept");
        src_a[2] = 1'b0; idle(1);
        rd(4'd0, 8'h04, "R4 sticky after drop");
        rd(4'd0, 8'h00, "R4 cleared after drop");
        // R5 reserved
        src_a[3] = 1'b1; idle(2); src_a[3] = 1'b0; idle(2);
        rd(4'd0, 8'h00, "R5 reserved silent");
        // R6 mask
        wr(4'd2, 8'hFE);
        src_a[0] = 1'b1; idle(1); src_a[0] = 1'b0; idle(2);
        chk("R6 masked no irq", irq_pin, 1'b0);
        rd(4'd0, 8'h00, "R6 masked status");
        wr(4'd2, 8'hFF);
        // R8 same-cycle event and read
        bus_addr = 4'd0; bus_rd = 1'b1; src_a[0] = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R8 old value returned", bus_rdata, 8'h00);
        rd(4'd0, 8'h01, "R8 event latched");
        // R9 bank B rising only
        src_b[5] = 1'b1; idle(2);
        rd(4'd1, 8'h20, "R9 bank B rise");
        idle(2);
        rd(4'd1, 8'h00, "R9 held high no retrigger");
        // R11 pin control
        src_b[0] = 1'b1; idle(2);
        chk("R10 bank B irq", irq_pin, 1'b1);
        wr(4'd6, 8'h01);
        chk("R11 low pin", irq_pin, 1'b0);
        chk("R11 low oe", irq_oe, 1'b1);
        wr(4'd6, 8'h02);
        chk("R11 open pin", irq_pin, 1'b0);
        chk("R11 open oe active", irq_oe, 1'b1);
        rd(4'd1, 8'h01, "R11 clear B");
        chk("R11 open oe idle", irq_oe, 1'b0);
        wr(4'd6, 8'h00);
        chk("R11 high idle", irq_pin, 1'b0);
        src_b[1] = 1'b1; idle(1);
        wr(4'd6, 8'h03);
        chk("R11 reserved as high", irq_pin, 1'b1);
        rd(4'd6, 8'h03, "R12 pin ctl readback");
        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule